// File: doc/BRIEF.md
# Passive Tag Operating Mode Sequencer

This block sequences the top-level operating modes of a contactless tag that draws its power from the reader field. While the power-good input is low it holds all of its state cleared and keeps the modulator silent. When power becomes good it fetches one configuration word through a request/acknowledge read port. Only after that word has arrived does it start sending. In the read mode it drives the modulator enable from a payload that rotates without end. The payload and the number of extracted field clocks that each bit lasts both come from the configuration word.

The reader signals to the tag by switching its field off. The block sees such a gap as missing rising edges on the extracted field clock. It times that absence with its own free-running sampling clock. A gap longer than the monostable time raises a gap indicator for an external command decoder. A gap much longer than that, seen while sending, stops transmission and opens a listening window. A valid-command strobe in that window starts execution. A done strobe from the command logic then returns the block to read mode. If no command arrives before the window times out, the block also returns to read mode.

Top module: `tag_mode_seq`

## Requirements
- R1: While `pwrGood` is low, and no later than two `clk` cycles after it falls, `mode` is 0 (reset) and both `modEn` and `cfgReq` are 0.
- R2: After `pwrGood` rises, `mode` becomes 1 (configuration). `cfgReq` is then held at 1 with `cfgAddr` equal to `CFG_ADDR` until `cfgAck` is seen. `modEn` stays 0 for the whole wait.
- R3: `cfgData` is captured in the cycle in which `cfgAck` is high, and `mode` becomes 2 (read) in the next cycle. Bits [1:0] hold a rate code, with clocks per bit = `BASE_RATE` << code (8, 16, 32 or 64 at the defaults). Bits [DATA_W+1:2] hold the payload.
- R4: In read mode `modEn` equals the current payload bit, sent MSB first. Each bit lasts exactly the decoded number of `rfClk` rising edges, counted from the moment read mode is entered. After the last bit the payload wraps to its first bit.
- R5: `gapFlag` is 1 once `TMONO` or more `clk` cycles have passed without an `rfClk` rising edge, and 0 again after the next edge. The gap timer also restarts on every entry into read mode.
- R6: In read mode, a gap of `LONG_GAP` `clk` cycles moves `mode` to 3 (listen), and `modEn` drops to 0. A shorter gap leaves read mode running.
- R7: In listen mode a `cmdValid` pulse moves `mode` to 4 (execute) with `cmdExec` at 1 and `modEn` at 0. A `cmdValid` pulse in read mode has no effect on `mode`.
- R8: In execute mode the block waits for `cmdDone`, then returns to read mode. Payload rotation resumes at the bit that was current when read mode was left, with the bit's edge count restarted from zero.
- R9: If listen mode sees no `cmdValid` for `LISTEN_TO` `clk` cycles, `mode` returns to 2 (read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| pwrGood | input | 1 | Asynchronous power-good level; low clears the block |
| rfClk | input | 1 | Clock extracted from the reader field; asynchronous to `clk` |
| cfgReq | output | 1 | Configuration read request |
| cfgAddr | output | ADDR_W | Address of the configuration word |
| cfgAck | input | 1 | One-cycle acknowledge; `cfgData` is valid in the same cycle |
| cfgData | input | DATA_W+2 | Configuration word: rate code in [1:0], payload above it |
| cmdValid | input | 1 | Strobe from the external decoder: a valid command pattern was seen |
| cmdDone | input | 1 | Strobe from the command logic: execution has finished |
| modEn | output | 1 | Modulator enable |
| mode | output | 3 | Operating mode: 0 reset, 1 configuration, 2 read, 3 listen, 4 execute |
| cmdExec | output | 1 | High while a command is being executed |
| gapFlag | output | 1 | Field gap longer than `TMONO` is in progress |

## Verification
The embedded properties guard, on every cycle, the rules that can be stated locally:
- the modulator stays quiet outside read mode;
- the block is in reset right after power is lost;
- a reset is always followed by the configuration fetch;
- a long gap in read mode preempts sending;
- a command strobe in listen mode is accepted, and listen times out;
- the gap timer counts without skipping;
- the payload only changes on a load or a bit boundary.

Other behaviour only shows up over a scenario, so the bench's scenarios cover it:
- the MSB-first bit order, the bit length chosen by each rate code, and the wrap of the payload;
- resuming at the right bit after an execute phase;
- the exact gap-indicator window;
- that a command strobe during sending is ignored.

// File: rtl/tms_pkg.sv
package tms_pkg;

  typedef enum logic [2:0] {
    MODE_RESET  = 3'd0,
    MODE_CONFIG = 3'd1,
    MODE_READ   = 3'd2,
    MODE_LISTEN = 3'd3,
    MODE_EXEC   = 3'd4
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture the configuration word
    logic restart;   // entering read mode: clear bit and gap timers
    logic txRun;     // read mode active
  } ctrl_t;

  localparam int RATE_CODE_W = 2;

endpackage

// File: rtl/tms_dpath.sv
module tms_dpath
  import tms_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BASE_RATE = 8,   // power of two
  parameter int TMONO     = 20,
  parameter int LONG_GAP  = 60
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              rfClk,
  input  logic [DATA_W+1:0] cfgData,
  input  ctrl_t             ctl,
  output logic              pwrOk,
  output logic              gapFlag,
  output logic              longGap,
  output logic              modEn
);

  localparam int MAX_RATE = BASE_RATE << ((1 << RATE_CODE_W) - 1);
  localparam int BIT_W    = $clog2(MAX_RATE);
  localparam int GAP_W    = $clog2(LONG_GAP + 1);
  localparam logic [GAP_W-1:0] TMONO_V = GAP_W'(TMONO);
  localparam logic [GAP_W-1:0] LONG_V  = GAP_W'(LONG_GAP);

  // power-good synchronizer: asynchronous clear, synchronous release
  logic [1:0] pgSync;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) pgSync <= '0;
    else          pgSync <= {pgSync[0], 1'b1};
  end
  assign pwrOk = pgSync[1];

  // field clock synchronizer and rising-edge detect
  logic [2:0] rfSync;
  logic       rfEdge;
  always_ff @(posedge clk) begin
    if (!pwrOk) rfSync <= '0;
    else        rfSync <= {rfSync[1:0], rfClk};
  end
  assign rfEdge = rfSync[1] & ~rfSync[2];

  // saturating gap timer
  logic [GAP_W-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!pwrOk || ctl.restart || rfEdge) gapCnt <= '0;
    else if (gapCnt != LONG_V)           gapCnt <= gapCnt + 1'b1;
  end
  assign gapFlag = (gapCnt >= TMONO_V);
  assign longGap = (gapCnt == LONG_V);

  // configuration and bit sequencing
  logic [RATE_CODE_W-1:0] rateCode;
  logic [DATA_W-1:0]      payload;
  logic [BIT_W-1:0]       bitCnt;
  logic [BIT_W:0]         perBit;
  logic                   bitLast;

  always_comb begin
    perBit  = (BIT_W+1)'(BASE_RATE) << rateCode;
    bitLast = ({1'b0, bitCnt} == (perBit - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!pwrOk) begin
      rateCode <= '0;
      payload  <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctl.loadCfg) begin
        rateCode <= cfgData[RATE_CODE_W-1:0];
        payload  <= cfgData[DATA_W+1:RATE_CODE_W];
      end
      if (ctl.restart) begin
        bitCnt <= '0;
      end else if (ctl.txRun && rfEdge) begin
        if (bitLast) begin
          bitCnt  <= '0;
          payload <= {payload[DATA_W-2:0], payload[DATA_W-1]};
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign modEn = ctl.txRun & payload[DATA_W-1];

  // R5
  gap_count_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (!rfEdge && !ctl.restart && !longGap) |=> (gapCnt == $past(gapCnt) + 1'b1));

  // R4
  payload_hold_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (!ctl.loadCfg && !(ctl.txRun && rfEdge)) |=> $stable(payload));

endmodule

// File: rtl/tms_ctrl.sv
module tms_ctrl
  import tms_pkg::*;
#(
  parameter int LISTEN_TO = 100
) (
  input  logic  clk,
  input  logic  pwrOk,
  input  logic  cfgAck,
  input  logic  cmdValid,
  input  logic  cmdDone,
  input  logic  longGap,
  output mode_t mode,
  output ctrl_t ctl
);

  localparam int TO_W = $clog2(LISTEN_TO + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(LISTEN_TO - 1);

  mode_t           next;
  logic [TO_W-1:0] toCnt;
  logic            toLast;

  assign toLast = (toCnt == TO_LAST);

  always_comb begin
    next = mode;
    case (mode)
      MODE_RESET:  next = MODE_CONFIG;
      MODE_CONFIG: if (cfgAck) next = MODE_READ;
      MODE_READ:   if (longGap) next = MODE_LISTEN;
      MODE_LISTEN: begin
        if (cmdValid)    next = MODE_EXEC;
        else if (toLast) next = MODE_READ;
      end
      MODE_EXEC:   if (cmdDone) next = MODE_READ;
      default:     next = MODE_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!pwrOk) begin
      mode  <= MODE_RESET;
      toCnt <= '0;
    end else begin
      mode  <= next;
      toCnt <= (mode == MODE_LISTEN && next == MODE_LISTEN) ? toCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    ctl.loadCfg = (mode == MODE_CONFIG) && cfgAck;
    ctl.restart = (mode != MODE_READ) && (next == MODE_READ);
    ctl.txRun   = (mode == MODE_READ);
  end

  // R2
  cfg_first_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (mode == MODE_RESET) |=> (mode == MODE_CONFIG));

  // R6
  long_gap_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (mode == MODE_READ && longGap) |=> (mode == MODE_LISTEN));

  // R7
  cmd_accept_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (mode == MODE_LISTEN && cmdValid) |=> (mode == MODE_EXEC));

  // R9
  listen_timeout_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (mode == MODE_LISTEN && !cmdValid && toLast) |=> (mode == MODE_READ));

endmodule

// File: rtl/tag_mode_seq.sv
module tag_mode_seq
  import tms_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BASE_RATE = 8,
  parameter int TMONO     = 20,
  parameter int LONG_GAP  = 60,
  parameter int LISTEN_TO = 100,
  parameter int ADDR_W    = 4,
  parameter int CFG_ADDR  = 1
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              rfClk,
  output logic              cfgReq,
  output logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgAck,
  input  logic [DATA_W+1:0] cfgData,
  input  logic              cmdValid,
  input  logic              cmdDone,
  output logic              modEn,
  output logic [2:0]        mode,
  output logic              cmdExec,
  output logic              gapFlag
);

  mode_t modeInt;
  ctrl_t ctl;
  logic  pwrOk;
  logic  longGap;

  tms_ctrl #(.LISTEN_TO(LISTEN_TO)) u_ctrl (
    .clk      (clk),
    .pwrOk    (pwrOk),
    .cfgAck   (cfgAck),
    .cmdValid (cmdValid),
    .cmdDone  (cmdDone),
    .longGap  (longGap),
    .mode     (modeInt),
    .ctl      (ctl)
  );

  tms_dpath #(
    .DATA_W    (DATA_W),
    .BASE_RATE (BASE_RATE),
    .TMONO     (TMONO),
    .LONG_GAP  (LONG_GAP)
  ) u_dpath (
    .clk     (clk),
    .pwrGood (pwrGood),
    .rfClk   (rfClk),
    .cfgData (cfgData),
    .ctl     (ctl),
    .pwrOk   (pwrOk),
    .gapFlag (gapFlag),
    .longGap (longGap),
    .modEn   (modEn)
  );

  assign mode    = modeInt;
  assign cfgReq  = (modeInt == MODE_CONFIG);
  assign cfgAddr = ADDR_W'(CFG_ADDR);
  assign cmdExec = (modeInt == MODE_EXEC);

  // R1
  off_in_reset_chk: assert property (@(posedge clk)
    !pwrOk |=> (modeInt == MODE_RESET && !modEn));

  // R2
  mod_quiet_chk: assert property (@(posedge clk) disable iff (!pwrOk)
    (modeInt != MODE_READ) |-> !modEn);

endmodule

// File: tb/tag_mode_seq_tb.sv
module tag_mode_seq_tb;

  localparam int DATA_W    = 16;
  localparam int BASE_RATE = 8;
  localparam int TMONO     = 20;
  localparam int LONG_GAP  = 60;
  localparam int LISTEN_TO = 100;
  localparam int ADDR_W    = 4;
  localparam int CFG_ADDR  = 1;

  logic              clk = 1'b0;
  logic              pwrGood = 1'b0;
  logic              rfClk = 1'b0;
  logic              cfgAck = 1'b0;
  logic [DATA_W+1:0] cfgData = '0;
  logic              cmdValid = 1'b0;
  logic              cmdDone = 1'b0;
  logic              cfgReq, modEn, cmdExec, gapFlag;
  logic [ADDR_W-1:0] cfgAddr;
  logic [2:0]        mode;

  always #2 clk = ~clk;

  tag_mode_seq #(
    .DATA_W(DATA_W), .BASE_RATE(BASE_RATE), .TMONO(TMONO), .LONG_GAP(LONG_GAP),
    .LISTEN_TO(LISTEN_TO), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
  ) u_dut (
    .clk(clk), .pwrGood(pwrGood), .rfClk(rfClk), .cfgReq(cfgReq), .cfgAddr(cfgAddr),
    .cfgAck(cfgAck), .cfgData(cfgData), .cmdValid(cmdValid), .cmdDone(cmdDone),
    .modEn(modEn), .mode(mode), .cmdExec(cmdExec), .gapFlag(gapFlag)
  );

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] curPayload;
  int curRate;
  int bitIdx;
  int sessEdges;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rateOf(input int code);
    return BASE_RATE << code;
  endfunction

  function automatic int expBit(input logic [DATA_W-1:0] p, input int idx);
    return int'(p[DATA_W-1 - (idx % DATA_W)]);
  endfunction

  task automatic newSession();
    bitIdx    = bitIdx + sessEdges / curRate;
    sessEdges = 0;
  endtask

  task automatic powerUp();
    @(negedge clk);
    pwrGood = 1'b1;
  endtask

  task automatic powerDown();
    @(negedge clk);
    pwrGood = 1'b0;
    rfClk   = 1'b0;
    repeat (2) @(negedge clk);
    chkEq("R1", "mode after power loss", mode, 0);
    chkEq("R1", "modEn after power loss", modEn, 0);
    chkEq("R1", "cfgReq after power loss", cfgReq, 0);
  endtask

  task automatic doConfig(input int code, input logic [DATA_W-1:0] pl, input int dly);
    while (!cfgReq) @(negedge clk);
    chkEq("R2", "mode in config", mode, 1);
    chkEq("R2", "cfgAddr", cfgAddr, CFG_ADDR);
    chkEq("R2", "modEn in config", modEn, 0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chkEq("R2", "cfgReq held", cfgReq, 1);
      chkEq("R2", "modEn quiet while waiting", modEn, 0);
    end
    cfgData = {pl, code[1:0]};
    cfgAck  = 1'b1;
    @(negedge clk);
    cfgAck  = 1'b0;
    chkEq("R3", "mode after ack", mode, 2);
    curPayload = pl;
    curRate    = rateOf(code);
    bitIdx     = 0;
    sessEdges  = 0;
  endtask

  task automatic runEdges(input int n);
    for (int i = 0; i < n; i++) begin
      chkEq("R4", "modEn bit", modEn, expBit(curPayload, bitIdx + sessEdges / curRate));
      if (sessEdges > 0) chkEq("R5", "gapFlag with field present", gapFlag, 0);
      rfClk = 1'b1;
      repeat (4) @(negedge clk);
      rfClk = 1'b0;
      repeat (4) @(negedge clk);
      sessEdges++;
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    curRate = BASE_RATE;
    bitIdx = 0;
    sessEdges = 0;
    curPayload = '0;

    // reset state
    repeat (5) @(negedge clk);
    chkEq("R1", "mode at reset", mode, 0);
    chkEq("R1", "modEn at reset", modEn, 0);
    chkEq("R1", "cfgReq at reset", cfgReq, 0);
    chkEq("R7", "cmdExec at reset", cmdExec, 0);

    // directed: fastest rate, full wrap of the payload
    powerUp();
    doConfig(0, 16'hA5C3, 3);
    runEdges(8 * DATA_W + 24);

    // gap timing, counted from the end of the last edge period
    repeat (10) @(negedge clk);
    chkEq("R5", "gapFlag below threshold", gapFlag, 0);
    chkEq("R6", "mode during short gap", mode, 2);
    repeat (6) @(negedge clk);
    chkEq("R5", "gapFlag past threshold", gapFlag, 1);
    repeat (34) @(negedge clk);
    chkEq("R6", "mode before long gap", mode, 2);
    repeat (10) @(negedge clk);
    chkEq("R6", "mode after long gap", mode, 3);
    chkEq("R6", "modEn in listen", modEn, 0);
    newSession();

    // listen timeout
    repeat (80) @(negedge clk);
    chkEq("R9", "still listening", mode, 3);
    repeat (20) @(negedge clk);
    chkEq("R9", "back to read after timeout", mode, 2);

    // field still off: long gap again, then a command
    repeat (60) @(negedge clk);
    chkEq("R6", "listen again", mode, 3);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chkEq("R7", "mode execute", mode, 4);
    chkEq("R7", "cmdExec", cmdExec, 1);
    chkEq("R7", "modEn in execute", modEn, 0);
    repeat (5) @(negedge clk);
    chkEq("R8", "execute held until done", mode, 4);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
    chkEq("R8", "mode after done", mode, 2);
    chkEq("R8", "cmdExec after done", cmdExec, 0);
    newSession();
    runEdges(2 * 8 + 3);

    // command strobe during read is ignored
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    chkEq("R7", "cmdValid ignored in read", mode, 2);
    runEdges(10);
    powerDown();

    // random configurations
    for (int it = 0; it < 6; it++) begin
      int code;
      int dly;
      logic [DATA_W-1:0] pl;
      code = $urandom % 4;
      dly  = $urandom % 6;
      pl   = DATA_W'($urandom);
      powerUp();
      doConfig(code, pl, dly);
      runEdges((curRate <= 16) ? curRate * DATA_W + curRate : 150);
      powerDown();
    end

    finishRun();
  end

endmodule